// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a bank of 32-bit control words that fills a 4 KB byte-addressed window, stored as 1024 words indexed by the byte address divided by four. A simple bus reaches it, with an address, write data, a write strobe and a read strobe. Each access takes one cycle. Read data and the error flag appear in the cycle after the access. The bus has no back-pressure, so every strobe is accepted in the cycle it is raised. Address bits [1:0] are ignored.

Out of reset the bank is locked. Software must write a 16-bit unlock key to one register before ordinary words accept writes, and it can re-lock the bank with a second key at another register. A status word reports the lock state. One word at offset 0x000 holds a single bit and stays writable while the bank is locked. A permission decoder classifies every word offset as read-write, read-only, write-only or unmapped, and flags any access that goes against that class. An accepted write with bit 0 set to the reset-control word at 0x200 produces a one-cycle soft-reset request.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the status word at 0x00C reads 1 (locked). The words at 0x100, 0x104 and 0x108 read 0x0001A008. The word at 0x10C reads 0x0000003F. The words at 0x110, 0x114 and 0x118 read 0x00014000. The 54 words 0x700+4k (k = 0..53) read 0x00001601, except k = 2..8, which read 0x00000601. The word at 0x25C reads 0x00000001 and the word at 0x530 reads the ID_CODE parameter.
- R2: A write to 0x004 whose data bits [15:0] equal LOCK_KEY sets the lock status to 1. Any other key leaves the status unchanged.
- R3: A write to 0x008 whose data bits [15:0] equal UNLOCK_KEY clears the lock status to 0. Any other key leaves the status unchanged.
- R4: A write to 0x000 stores only data bit 0, with bits [31:1] reading as 0, and it takes effect whether or not the bank is locked.
- R5: A write to any other writable word stores all 32 bits only while the lock status is 0. While the status is 1 the write is dropped and the word keeps its old value. Read data appears in the cycle after the read strobe.
- R6: Read-only offsets are 0x00C, 0x10C, 0x17C, 0x18C, 0x19C, 0x1AC, 0x25C and 0x530. A write to a read-only or unmapped offset changes no state and raises access_err for exactly the one cycle after the write.
- R7: Write-only offsets are 0x004, 0x008, 0x60C and 0x614. A read from a write-only or unmapped offset raises access_err for the one cycle after the read, and it still returns the stored word (0 where nothing was stored).
- R8: An accepted write to 0x200 with data bit 0 set raises soft_reset_req for exactly the one following cycle. A write with bit 0 clear, or one made while the bank is locked, raises no request.
- R9: Read-write offsets are 0x000, 0x100–0x108, 0x110–0x118, 0x120–0x16C, 0x170–0x1AC (excluding the read-only status words), 0x200–0x244 and 0x700–0x7D4. Every other offset is unmapped. An accepted access to a read-write offset raises no access_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| access_err | output | 1 | One-cycle pulse after a disallowed access |
| soft_reset_req | output | 1 | One-cycle soft-reset request |

## Verification
Random single accesses are drawn from a pool that covers every permission class, the lock, unlock and status words, the single-bit word and the reset-control word. A few random offsets are mixed in. Each access is compared with a bench model of the word array and the lock state. Lock and unlock writes alternate between correct and wrong keys, so one run crosses locked and unlocked phases many times. That tells a dropped write apart from a stored one, and a real error apart from a mistaken one. Directed cases check the reset image, key mismatches, the lock bypass of offset 0x000, and a reset-control write with bit 0 clear, with bit 0 set, and while locked.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [1:0] {
    ACC_RW       = 2'd0,
    ACC_RO       = 2'd1,
    ACC_WO       = 2'd2,
    ACC_UNMAPPED = 2'd3
  } acc_class_e;

  localparam int unsigned IDX_W       = 10;
  localparam int unsigned IDX_SINGLE  = 10'h000;
  localparam int unsigned IDX_LOCK    = 10'h001;
  localparam int unsigned IDX_UNLOCK  = 10'h002;
  localparam int unsigned IDX_STATUS  = 10'h003;
  localparam int unsigned IDX_RSTCTL  = 10'h080;
  localparam int unsigned PINMUX_BASE = 10'h1C0;
  localparam int unsigned PINMUX_CNT  = 54;

  function automatic acc_class_e classify(input logic [IDX_W-1:0] idx);
    acc_class_e c;
    c = ACC_UNMAPPED;
    if (idx == 10'h000) c = ACC_RW;
    else if (idx == 10'h001 || idx == 10'h002) c = ACC_WO;
    else if (idx == 10'h003) c = ACC_RO;
    else if (idx >= 10'h040 && idx <= 10'h042) c = ACC_RW;
    else if (idx == 10'h043) c = ACC_RO;
    else if (idx >= 10'h044 && idx <= 10'h046) c = ACC_RW;
    else if (idx >= 10'h048 && idx <= 10'h05B) c = ACC_RW;
    else if (idx >= 10'h05C && idx <= 10'h06B) c = (idx[1:0] == 2'b11) ? ACC_RO : ACC_RW;
    else if (idx >= 10'h080 && idx <= 10'h091) c = ACC_RW;
    else if (idx == 10'h097) c = ACC_RO;
    else if (idx == 10'h14C) c = ACC_RO;
    else if (idx == 10'h183 || idx == 10'h185) c = ACC_WO;
    else if (idx >= PINMUX_BASE[IDX_W-1:0] && idx < IDX_W'(PINMUX_BASE + PINMUX_CNT)) c = ACC_RW;
    return c;
  endfunction

  function automatic logic [31:0] reset_word(input logic [IDX_W-1:0] idx, input logic [31:0] id_code);
    logic [31:0] v;
    int unsigned k;
    v = 32'h0;
    k = int'(idx) - int'(PINMUX_BASE);
    if (idx >= 10'h040 && idx <= 10'h042) v = 32'h0001_A008;
    else if (idx == 10'h043) v = 32'h0000_003F;
    else if (idx >= 10'h044 && idx <= 10'h046) v = 32'h0001_4000;
    else if (idx >= 10'h05C && idx <= 10'h06B && idx[1:0] == 2'b11) v = 32'h0001_0000;
    else if (idx == 10'h097) v = 32'h0000_0001;
    else if (idx == 10'h14C) v = id_code;
    else if (idx >= PINMUX_BASE[IDX_W-1:0] && idx < IDX_W'(PINMUX_BASE + PINMUX_CNT))
      v = (k >= 2 && k <= 8) ? 32'h0000_0601 : 32'h0000_1601;
    return v;
  endfunction

endpackage

// File: rtl/sysctl_access_decode.sv
module sysctl_access_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned IW = 10
) (
  input  logic [IW-1:0] idx,
  input  logic          we,
  input  logic          re,
  output acc_class_e    cls,
  output logic          bad_access
);
  logic wr_bad, rd_bad;

  always_comb begin
    cls    = classify(idx);
    wr_bad = we && (cls == ACC_RO || cls == ACC_UNMAPPED);
    rd_bad = re && (cls == ACC_WO || cls == ACC_UNMAPPED);
    bad_access = wr_bad || rd_bad;
  end
endmodule

// File: rtl/sysctl_lock_ctrl.sv
module sysctl_lock_ctrl #(
  parameter int unsigned IW         = 10,
  parameter logic [15:0] LOCK_KEY   = 16'hC10A,
  parameter logic [15:0] UNLOCK_KEY = 16'h0FA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [15:0]   key,
  output logic          locked
);
  localparam logic [IW-1:0] LOCK_IDX   = IW'(1);
  localparam logic [IW-1:0] UNLOCK_IDX = IW'(2);

  logic set_lock, clr_lock;

  always_comb begin
    set_lock = we && (idx == LOCK_IDX)   && (key == LOCK_KEY);
    clr_lock = we && (idx == UNLOCK_IDX) && (key == UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b1;
    else if (set_lock) locked <= 1'b1;
    else if (clr_lock) locked <= 1'b0;
  end
endmodule

// File: rtl/sysctl_word_store.sv
module sysctl_word_store
  import sysctl_pkg::*;
#(
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned DW      = 32,
  parameter logic [31:0] ID_CODE = 32'h0000_5A17,
  localparam int unsigned IW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= DW'(reset_word(IDX_W'(i), ID_CODE));
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 32,
  parameter logic [15:0] LOCK_KEY   = 16'hC10A,
  parameter logic [15:0] UNLOCK_KEY = 16'h0FA5,
  parameter logic [31:0] ID_CODE    = 32'h0000_5A17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          access_err,
  output logic          soft_reset_req
);
  localparam int unsigned IW    = AW - 2;
  localparam int unsigned DEPTH = 1 << IW;

  logic [IW-1:0] idx;
  acc_class_e    cls;
  logic          bad_access;
  logic          locked;
  logic          store_we;
  logic [DW-1:0] store_data;
  logic [DW-1:0] stored;
  logic          is_single, is_key_reg, writable;

  assign idx = bus_addr[AW-1:2];

  sysctl_access_decode #(.IW(IW)) u_decode (
    .idx        (idx),
    .we         (bus_we),
    .re         (bus_re),
    .cls        (cls),
    .bad_access (bad_access)
  );

  sysctl_lock_ctrl #(
    .IW(IW), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bus_we),
    .idx    (idx),
    .key    (bus_wdata[15:0]),
    .locked (locked)
  );

  always_comb begin
    is_single  = (idx == IW'(IDX_SINGLE));
    is_key_reg = (idx == IW'(IDX_LOCK)) || (idx == IW'(IDX_UNLOCK));
    writable   = (cls == ACC_RW) || (cls == ACC_WO);
    store_we   = bus_we && writable && !is_key_reg && (is_single || !locked);
    store_data = is_single ? {{(DW-1){1'b0}}, bus_wdata[0]} : bus_wdata;
  end

  sysctl_word_store #(.DEPTH(DEPTH), .DW(DW), .ID_CODE(ID_CODE)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_we),
    .wr_idx  (idx),
    .wr_data (store_data),
    .rd_idx  (idx),
    .rd_word (stored)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata      <= '0;
      access_err     <= 1'b0;
      soft_reset_req <= 1'b0;
    end else begin
      access_err     <= bad_access;
      soft_reset_req <= store_we && (idx == IW'(IDX_RSTCTL)) && bus_wdata[0];
      if (bus_re)
        bus_rdata <= (idx == IW'(IDX_STATUS)) ? {{(DW-1){1'b0}}, locked} : stored;
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 32,
  parameter logic [15:0] LOCK_KEY   = 16'hC10A,
  parameter logic [15:0] UNLOCK_KEY = 16'h0FA5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_rdata,
  input logic          access_err,
  input logic          soft_reset_req,
  input logic          locked
);
  localparam logic [AW-3:0] W_SINGLE = '0;
  localparam logic [AW-3:0] W_LOCK   = (AW-2)'(1);
  localparam logic [AW-3:0] W_UNLOCK = (AW-2)'(2);
  localparam logic [AW-3:0] W_RSTCTL = (AW-2)'(128);

  // R2
  lock_key_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:2] == W_LOCK && bus_wdata[15:0] == LOCK_KEY) |=> locked);

  // R3
  unlock_key_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:2] == W_UNLOCK && bus_wdata[15:0] == UNLOCK_KEY
     && !(bus_addr[AW-1:2] == W_LOCK)) |=> !locked);

  // R4
  single_bit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[AW-1:2] == W_SINGLE) |=> (bus_rdata[DW-1:1] == '0));

  // R8
  soft_reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:2] == W_RSTCTL && bus_wdata[0] && !locked) |=> soft_reset_req);

  // R8
  soft_reset_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:2] == W_RSTCTL && locked) |=> !soft_reset_req);

  // R6
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !bus_re) |=> !access_err);
endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .AW(AW), .DW(DW), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .access_err(access_err), .soft_reset_req(soft_reset_req), .locked(locked)
);

// File: tb/tb_sysctl_regfile.sv
`timescale 1ns/1ps
module tb_sysctl_regfile;
  localparam logic [15:0] LKEY = 16'hC10A;
  localparam logic [15:0] UKEY = 16'h0FA5;
  localparam logic [31:0] IDC  = 32'h0000_5A17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        access_err, soft_reset_req;

  int checks = 0, failures = 0;
  logic [31:0] model [1024];
  bit          mlock;

  always #2 clk = ~clk;

  sysctl_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .access_err(access_err), .soft_reset_req(soft_reset_req)
  );

  // 0 rw, 1 ro, 2 wo, 3 unmapped  (from R6, R7, R9)
  function automatic int kind(input int a);
    if (a == 'h000) return 0;
    if (a == 'h004 || a == 'h008 || a == 'h60C || a == 'h614) return 2;
    if (a == 'h00C || a == 'h10C || a == 'h17C || a == 'h18C || a == 'h19C ||
        a == 'h1AC || a == 'h25C || a == 'h530) return 1;
    if (a >= 'h100 && a <= 'h118) return 0;
    if (a >= 'h120 && a <= 'h1AC) return 0;
    if (a >= 'h200 && a <= 'h244) return 0;
    if (a >= 'h700 && a <= 'h7D4) return 0;
    return 3;
  endfunction

  function automatic logic [31:0] init_val(input int a);
    if (a >= 'h100 && a <= 'h108) return 32'h0001A008;
    if (a == 'h10C) return 32'h3F;
    if (a >= 'h110 && a <= 'h118) return 32'h00014000;
    if (a == 'h17C || a == 'h18C || a == 'h19C || a == 'h1AC) return 32'h00010000;
    if (a == 'h25C) return 32'h1;
    if (a == 'h530) return IDC;
    if (a >= 'h700 && a <= 'h7D4) begin
      if (((a - 'h700) / 4) >= 2 && ((a - 'h700) / 4) <= 8) return 32'h601;
      return 32'h1601;
    end
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one bus access; outputs sampled one cycle later at the falling edge
  task automatic access(input bit wr, input int a, input logic [31:0] d, input string req);
    int k;
    bit exp_err, exp_sr;
    logic [31:0] exp_rd;
    k = kind(a);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = d; bus_we = wr; bus_re = !wr;
    exp_err = wr ? (k == 1 || k == 3) : (k == 2 || k == 3);
    exp_rd  = (a == 'h00C) ? {31'b0, mlock} : model[a/4];
    exp_sr  = 1'b0;
    if (wr) begin
      if (a == 'h004 && d[15:0] == LKEY) mlock = 1'b1;
      else if (a == 'h008 && d[15:0] == UKEY) mlock = 1'b0;
      else if (a == 'h000) model[0] = {31'b0, d[0]};
      else if ((k == 0 || k == 2) && a != 'h004 && a != 'h008 && !mlock) begin
        model[a/4] = d;
        exp_sr = (a == 'h200) && d[0];
      end
    end
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk({req, " err"}, {31'b0, access_err}, {31'b0, exp_err});
    chk({req, " sreset"}, {31'b0, soft_reset_req}, {31'b0, exp_sr});
    if (!wr) chk({req, " rdata"}, bus_rdata, exp_rd);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int pool [22] = '{'h000,'h004,'h008,'h00C,'h100,'h10C,'h110,'h120,'h17C,'h170,
                      'h200,'h244,'h25C,'h530,'h60C,'h614,'h700,'h708,'h720,'h7D4,'h7D8,'hA04};
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) model[i] = init_val(i * 4);
    mlock = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset image
    access(0, 'h00C, 0, "R1");
    access(0, 'h104, 0, "R1");
    access(0, 'h10C, 0, "R1");
    access(0, 'h118, 0, "R1");
    access(0, 'h700, 0, "R1");
    access(0, 'h708, 0, "R1");
    access(0, 'h720, 0, "R1");
    access(0, 'h724, 0, "R1");
    access(0, 'h25C, 0, "R1");
    access(0, 'h530, 0, "R1");
    // R5 locked write dropped
    access(1, 'h120, 32'hDEADBEEF, "R5");
    access(0, 'h120, 0, "R5");
    // R4 bypass while locked
    access(1, 'h000, 32'hFFFF_FFFF, "R4");
    access(0, 'h000, 0, "R4");
    // R8 locked reset-control write
    access(1, 'h200, 32'h1, "R8");
    // R3 wrong then right key
    access(1, 'h008, {16'h0, UKEY ^ 16'h1}, "R3");
    access(0, 'h00C, 0, "R3");
    access(1, 'h008, {16'hABCD, UKEY}, "R3");
    access(0, 'h00C, 0, "R3");
    // R5 stored when unlocked
    access(1, 'h120, 32'hDEADBEEF, "R5");
    access(0, 'h120, 0, "R5");
    // R8 bit0 clear, bit0 set
    access(1, 'h200, 32'h2, "R8");
    access(1, 'h200, 32'h3, "R8");
    // R6 write to read-only
    access(1, 'h10C, 32'h0, "R6");
    access(0, 'h10C, 0, "R6");
    access(1, 'hFFC, 32'h5, "R6");
    // R7 read write-only and unmapped
    access(1, 'h60C, 32'h1234_5678, "R7");
    access(0, 'h60C, 0, "R7");
    access(0, 'h004, 0, "R7");
    access(0, 'hFFC, 0, "R7");
    // R2 wrong then right lock key
    access(1, 'h004, {16'h0, LKEY ^ 16'h8000}, "R2");
    access(0, 'h00C, 0, "R2");
    access(1, 'h004, {16'h0, LKEY}, "R2");
    access(0, 'h00C, 0, "R2");

    // R9 random mix across all classes
    for (int n = 0; n < 3000; n++) begin
      int a;
      int r;
      logic [31:0] d;
      r = int'($urandom_range(0, 9));
      a = (r == 0) ? int'($urandom_range(0, 1023)) * 4 : pool[$urandom_range(0, 21)];
      d = $urandom;
      if (a == 'h004 && $urandom_range(0, 1) == 1) d[15:0] = LKEY;
      if (a == 'h008 && $urandom_range(0, 2) != 0) d[15:0] = UKEY;
      access($urandom_range(0, 1) == 1, a, d, "R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule